// File: doc/BRIEF.md
# UART Inbound XON/XOFF Flow-Control Detector

This block sits between a UART receiver and its receive FIFO. It inspects every character the receiver completes and compares it with four programmable codes: two stop codes and two resume codes. A recognised stop sequence raises `tx_halt_o`. The transmitter samples this level only between characters, so it always finishes the character it is sending before it pauses. A recognised resume sequence drops the level again. Flow-control characters are consumed. Every other character is passed to the FIFO write port one clock after its strobe.

Each direction matches either one code or a back-to-back pair of codes. In pair mode the first character of a pair is held back until the next character arrives. If that character does not complete the pair, the held character is replayed to the FIFO first and the new one follows a cycle later. Two further modes are available. In the first, any character resumes transmission. In the second, the second stop code only raises an interrupt and does not halt. Hardware handshake flow control is handled elsewhere and is never active at the same time as this block.

The replay path requires at least one idle cycle between receive strobes. A real UART character period is always far longer than that.

Top module: `xonxoff_detect`

## Requirements
- R1: After reset, `tx_halt_o`=0, `fc_irq_o`=0, `irq_n_o`=1 and `fifo_we_o`=0.
- R2: With flow control on, pair mode off and the transmitter running, a character equal to `xoff1_code_i` sets `tx_halt_o` one cycle after its strobe and is not written to the FIFO.
- R3: A completed stop match sets `fc_irq_o` only if `fc_irq_en_i` is 1. `irq_n_o` is always the inverse of `fc_irq_o`.
- R4: While halted in single mode, a character equal to `xon1_code_i` clears `tx_halt_o` and the stop interrupt one cycle after its strobe and is not written. While halted, any other character is written.
- R5: In pair mode, `xoff1_code_i` followed directly by `xoff2_code_i` sets `tx_halt_o`. Neither character is written.
- R6: In pair mode, if a held first character is not followed by its partner, the held character is written one cycle after the new strobe. The new character is written one cycle after that, unless it is itself a new first character, in which case it is held in turn.
- R7: While halted in pair mode, `xon1_code_i` followed directly by `xon2_code_i` clears `tx_halt_o`. Neither character is written, and the first character alone does not resume transmission.
- R8: In any-resume mode, the first character received while halted clears `tx_halt_o`. That character is written unless it equals `xon1_code_i`. A following `xon2_code_i` is then written as data.
- R9: In special-character mode, a character equal to `xoff2_code_i` that is not part of a flow-control match sets `fc_irq_o` when enabled. It does not halt, and it is written.
- R10: A pulse on `iid_read_i` clears an interrupt raised by the special character. It does not clear an interrupt raised by a stop match.
- R11: One cycle after flow control is turned off, `tx_halt_o` and the stop interrupt are 0. While it is off, every character is written.
- R12: A written character appears on `fifo_data_o` with `fifo_we_o` high for exactly one cycle, one cycle after its strobe. A resume code received while running is ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a received character is ready |
| rx_data_i | input | DW | Received character |
| xoff1_code_i | input | DW | First (or only) stop code |
| xoff2_code_i | input | DW | Second stop code; also the special character |
| xon1_code_i | input | DW | First (or only) resume code |
| xon2_code_i | input | DW | Second resume code |
| sw_fc_en_i | input | 1 | Enables stop/resume detection |
| pair_mode_i | input | 1 | 1: codes must arrive as back-to-back pairs |
| xon_any_i | input | 1 | 1: any character resumes while halted |
| special_en_i | input | 1 | 1: second stop code raises an interrupt only |
| fc_irq_en_i | input | 1 | Enables the flow-control interrupt |
| iid_read_i | input | 1 | Interrupt-identification read strobe |
| tx_halt_o | output | 1 | Transmit pause, sampled by the transmitter between characters |
| fc_irq_o | output | 1 | Flow-control interrupt flag |
| irq_n_o | output | 1 | Interrupt line, active low |
| fifo_we_o | output | 1 | Receive FIFO write enable |
| fifo_data_o | output | DW | Character to write into the FIFO |

## Verification
A corrupted match sequencer shows up at the FIFO port first, one or two cycles after the strobe that should have completed or abandoned a pair. It appears either as a missing replayed character or as a flow-control code leaking into the data stream. A wrong halt state appears on `tx_halt_o` one cycle after the deciding character, and it stays wrong until the next flow-control character. A wrong interrupt source is only visible when it is cleared: an identification read must drop a special-character interrupt and must leave a stop interrupt in place.

// File: rtl/xonxoff_detect_pkg.sv
package xonxoff_detect_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_SEEN} seq_e;
  localparam int NCODES   = 4;
  localparam int IDX_OFF1 = 0;
  localparam int IDX_OFF2 = 1;
  localparam int IDX_ON1  = 2;
  localparam int IDX_ON2  = 3;
endpackage

// File: rtl/xonxoff_detect_match.sv
module xonxoff_detect_match #(
  parameter int DW = 8,
  parameter int NC = 4
) (
  input  logic [DW-1:0]         data_i,
  input  logic [NC-1:0][DW-1:0] code_i,
  output logic [NC-1:0]         hit_o
);
  for (genvar i = 0; i < NC; i++) begin : g_cmp
    assign hit_o[i] = (data_i == code_i[i]);
  end
endmodule

// File: rtl/xonxoff_detect_seq.sv
module xonxoff_detect_seq
  import xonxoff_detect_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [NCODES-1:0] hit_i,
  input  logic              en_i,
  input  logic              pair_i,
  input  logic              any_i,
  input  logic              special_i,
  output logic              halt_o,
  output logic              xoff_hit_o,
  output logic              xon_hit_o,
  output logic              spec_hit_o,
  output logic              fwd_cur_o,
  output logic              fwd_held_o,
  output logic              start_o
);
  seq_e seq_q, seq_d;
  logic halted_q, halted_d;
  logic any_case, first, second, seen, complete, start, fwd_cur;

  always_comb begin
    any_case = halted_q && any_i;
    first    = halted_q ? hit_i[IDX_ON1] : hit_i[IDX_OFF1];
    second   = halted_q ? hit_i[IDX_ON2] : hit_i[IDX_OFF2];
    seen     = (seq_q == SEQ_SEEN);
    complete = en_i && (any_case || (pair_i ? (seen && second) : first));
    start    = en_i && !any_case && pair_i && !complete && first;
    fwd_cur  = !en_i || (any_case ? !hit_i[IDX_ON1] : (!complete && !start));
  end

  assign xoff_hit_o = valid_i && complete && !halted_q;
  assign xon_hit_o  = valid_i && complete && halted_q;
  assign start_o    = valid_i && start;
  assign fwd_cur_o  = valid_i && fwd_cur;
  assign fwd_held_o = valid_i && seen && (!complete || any_case);
  assign spec_hit_o = valid_i && special_i && hit_i[IDX_OFF2] && fwd_cur;

  always_comb begin
    seq_d = seq_q;
    if (valid_i) seq_d = start ? SEQ_SEEN : SEQ_IDLE;
    halted_d = halted_q;
    if (!en_i) halted_d = 1'b0;
    else if (valid_i && complete) halted_d = !halted_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q    <= SEQ_IDLE;
      halted_q <= 1'b0;
    end else begin
      seq_q    <= seq_d;
      halted_q <= halted_d;
    end
  end

  assign halt_o = halted_q;
endmodule

// File: rtl/xonxoff_detect_irq.sv
module xonxoff_detect_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic irq_en_i,
  input  logic xoff_hit_i,
  input  logic xon_hit_i,
  input  logic spec_hit_i,
  input  logic iid_read_i,
  output logic flag_o,
  output logic irq_n_o
);
  logic stop_q, spec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      spec_q <= 1'b0;
    end else begin
      if (!en_i)                       stop_q <= 1'b0;
      else if (xoff_hit_i && irq_en_i) stop_q <= 1'b1;
      else if (xon_hit_i)              stop_q <= 1'b0;
      // a new special hit wins over a concurrent read
      if (spec_hit_i && irq_en_i)      spec_q <= 1'b1;
      else if (iid_read_i)             spec_q <= 1'b0;
    end
  end

  assign flag_o  = stop_q | spec_q;
  assign irq_n_o = ~(stop_q | spec_q);
endmodule

// File: rtl/xonxoff_detect_fwd.sv
module xonxoff_detect_fwd #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          fwd_cur_i,
  input  logic          fwd_held_i,
  input  logic          start_i,
  output logic          we_o,
  output logic [DW-1:0] data_o
);
  logic          we_q, pend_q;
  logic [DW-1:0] data_q, pend_d_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q     <= 1'b0;
      pend_q   <= 1'b0;
      data_q   <= '0;
      pend_d_q <= '0;
      hold_q   <= '0;
    end else begin
      we_q <= 1'b0;
      if (valid_i) begin
        if (start_i) hold_q <= data_i;
        if (fwd_held_i) begin
          we_q   <= 1'b1;
          data_q <= hold_q;
          if (fwd_cur_i) begin
            pend_q   <= 1'b1;
            pend_d_q <= data_i;
          end
        end else if (fwd_cur_i) begin
          we_q   <= 1'b1;
          data_q <= data_i;
        end
      end else if (pend_q) begin
        we_q   <= 1'b1;
        data_q <= pend_d_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign we_o   = we_q;
  assign data_o = data_q;
endmodule

// File: rtl/xonxoff_detect.sv
module xonxoff_detect
  import xonxoff_detect_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic [DW-1:0] xoff1_code_i,
  input  logic [DW-1:0] xoff2_code_i,
  input  logic [DW-1:0] xon1_code_i,
  input  logic [DW-1:0] xon2_code_i,
  input  logic          sw_fc_en_i,
  input  logic          pair_mode_i,
  input  logic          xon_any_i,
  input  logic          special_en_i,
  input  logic          fc_irq_en_i,
  input  logic          iid_read_i,
  output logic          tx_halt_o,
  output logic          fc_irq_o,
  output logic          irq_n_o,
  output logic          fifo_we_o,
  output logic [DW-1:0] fifo_data_o
);
  logic [NCODES-1:0][DW-1:0] codes;
  logic [NCODES-1:0]         hit;
  logic xoff_hit, xon_hit, spec_hit, fwd_cur, fwd_held, start;

  always_comb begin
    codes[IDX_OFF1] = xoff1_code_i;
    codes[IDX_OFF2] = xoff2_code_i;
    codes[IDX_ON1]  = xon1_code_i;
    codes[IDX_ON2]  = xon2_code_i;
  end

  xonxoff_detect_match #(.DW(DW), .NC(NCODES)) u_match (
    .data_i (rx_data_i),
    .code_i (codes),
    .hit_o  (hit)
  );

  xonxoff_detect_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (rx_valid_i),
    .hit_i      (hit),
    .en_i       (sw_fc_en_i),
    .pair_i     (pair_mode_i),
    .any_i      (xon_any_i),
    .special_i  (special_en_i),
    .halt_o     (tx_halt_o),
    .xoff_hit_o (xoff_hit),
    .xon_hit_o  (xon_hit),
    .spec_hit_o (spec_hit),
    .fwd_cur_o  (fwd_cur),
    .fwd_held_o (fwd_held),
    .start_o    (start)
  );

  xonxoff_detect_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (sw_fc_en_i),
    .irq_en_i   (fc_irq_en_i),
    .xoff_hit_i (xoff_hit),
    .xon_hit_i  (xon_hit),
    .spec_hit_i (spec_hit),
    .iid_read_i (iid_read_i),
    .flag_o     (fc_irq_o),
    .irq_n_o    (irq_n_o)
  );

  xonxoff_detect_fwd #(.DW(DW)) u_fwd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (rx_valid_i),
    .data_i     (rx_data_i),
    .fwd_cur_i  (fwd_cur),
    .fwd_held_i (fwd_held),
    .start_i    (start),
    .we_o       (fifo_we_o),
    .data_o     (fifo_data_o)
  );
endmodule

// File: rtl/xonxoff_detect_chk.sv
module xonxoff_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic sw_fc_en_i,
  input logic fc_irq_en_i,
  input logic tx_halt_o,
  input logic fc_irq_o,
  input logic fifo_we_o
);
  // R2
  halt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_halt_o) |-> $past(rx_valid_i && sw_fc_en_i));

  // R4
  halt_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_halt_o) |-> $past(rx_valid_i || !sw_fc_en_i));

  // R3
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fc_irq_o) |-> $past(rx_valid_i && fc_irq_en_i));

  // R11
  fc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sw_fc_en_i) |-> !tx_halt_o);

  // R12
  write_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> $past(rx_valid_i || fifo_we_o));
endmodule

bind xonxoff_detect xonxoff_detect_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .sw_fc_en_i  (sw_fc_en_i),
  .fc_irq_en_i (fc_irq_en_i),
  .tx_halt_o   (tx_halt_o),
  .fc_irq_o    (fc_irq_o),
  .fifo_we_o   (fifo_we_o)
);

// File: tb/xonxoff_detect_test.sv
`timescale 1ns/1ps
module xonxoff_detect_test;
  localparam int DW = 8;
  localparam logic [7:0] OFF1 = 8'h13, OFF2 = 8'h93, ON1 = 8'h11, ON2 = 8'h91;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_v = 1'b0, en = 1'b0, pair = 1'b0, any = 1'b0, spec = 1'b0;
  logic irq_en = 1'b0, iid = 1'b0;
  logic [DW-1:0] rx_d = '0;
  logic halt, flag, irq_n, we;
  logic [DW-1:0] fdata;
  int checks = 0, fails = 0;
  logic w1, w2;
  logic [7:0] d1, d2;

  always #2 clk = ~clk;

  xonxoff_detect #(.DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_v), .rx_data_i(rx_d),
    .xoff1_code_i(OFF1), .xoff2_code_i(OFF2), .xon1_code_i(ON1), .xon2_code_i(ON2),
    .sw_fc_en_i(en), .pair_mode_i(pair), .xon_any_i(any), .special_en_i(spec),
    .fc_irq_en_i(irq_en), .iid_read_i(iid),
    .tx_halt_o(halt), .fc_irq_o(flag), .irq_n_o(irq_n),
    .fifo_we_o(we), .fifo_data_o(fdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // strobe one character, record FIFO port on the two following cycles
  task automatic send(input logic [7:0] c);
    @(negedge clk); rx_v = 1'b1; rx_d = c;
    @(negedge clk); rx_v = 1'b0; w1 = we; d1 = fdata;
    @(negedge clk); w2 = we; d2 = fdata;
  endtask

  task automatic pulse_iid();
    @(negedge clk); iid = 1'b1;
    @(negedge clk); iid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 halt", halt, 0); chk("R1 flag", flag, 0);
    chk("R1 irq_n", irq_n, 1); chk("R1 we", we, 0);
  endtask

  task automatic t_plain();
    send(8'h41);
    chk("R12 we", w1, 1); chk("R12 data", d1, 8'h41); chk("R12 one pulse", w2, 0);
    send(ON1);
    chk("R12 xon while running written", w1, 1); chk("R12 xon data", d1, ON1);
    chk("R12 no halt", halt, 0);
  endtask

  task automatic t_single();
    send(OFF1);
    chk("R2 halt", halt, 1); chk("R2 consumed", w1 | w2, 0);
    chk("R3 flag", flag, 1); chk("R3 irq_n", irq_n, 0);
    send(8'h42);
    chk("R4 data while halted", w1, 1); chk("R4 still halted", halt, 1);
    send(ON1);
    chk("R4 resume", halt, 0); chk("R4 flag clr", flag, 0);
    chk("R4 irq_n", irq_n, 1); chk("R4 consumed", w1 | w2, 0);
  endtask

  task automatic t_noirq();
    irq_en = 1'b0;
    send(OFF1);
    chk("R3 halt w/o irq", halt, 1); chk("R3 no flag", flag, 0); chk("R3 irq_n hi", irq_n, 1);
    send(ON1);
    chk("R4 resume w/o irq", halt, 0);
    irq_en = 1'b1;
  endtask

  task automatic t_pair();
    pair = 1'b1;
    send(OFF1);
    chk("R5 first alone no halt", halt, 0); chk("R5 first held", w1 | w2, 0);
    send(OFF2);
    chk("R5 halt", halt, 1); chk("R5 consumed", w1 | w2, 0);
    send(ON1);
    chk("R7 first alone keeps halt", halt, 1); chk("R7 held", w1 | w2, 0);
    send(ON2);
    chk("R7 resume", halt, 0); chk("R7 consumed", w1 | w2, 0);
    pair = 1'b0;
  endtask

  task automatic t_abandon();
    pair = 1'b1;
    send(OFF1);
    send(8'h55);
    chk("R6 held replay we", w1, 1); chk("R6 held replay data", d1, OFF1);
    chk("R6 new we", w2, 1); chk("R6 new data", d2, 8'h55); chk("R6 no halt", halt, 0);
    send(OFF1);
    send(OFF1);
    chk("R6 replay on restart", w1, 1); chk("R6 replay data", d1, OFF1);
    chk("R6 new first held", w2, 0);
    send(OFF2);
    chk("R6 restart completes", halt, 1);
    send(ON1); send(ON2);
    chk("R7 release", halt, 0);
    pair = 1'b0;
  endtask

  task automatic t_any();
    any = 1'b1;
    send(OFF1);
    chk("R8 halt", halt, 1);
    send(8'h60);
    chk("R8 any resumes", halt, 0); chk("R8 written", w1, 1); chk("R8 data", d1, 8'h60);
    send(OFF1);
    send(ON1);
    chk("R8 xon1 resumes", halt, 0); chk("R8 xon1 consumed", w1 | w2, 0);
    send(ON2);
    chk("R8 xon2 is data", w1, 1); chk("R8 xon2 data", d1, ON2);
    any = 1'b0;
  endtask

  task automatic t_special();
    spec = 1'b1;
    send(OFF2);
    chk("R9 flag", flag, 1); chk("R9 no halt", halt, 0);
    chk("R9 written", w1, 1); chk("R9 data", d1, OFF2);
    pulse_iid();
    chk("R10 read clears special", flag, 0);
    send(OFF1);
    chk("R10 stop flag", flag, 1);
    pulse_iid();
    chk("R10 read keeps stop flag", flag, 1);
    send(ON1);
    chk("R10 xon clears", flag, 0);
    spec = 1'b0;
  endtask

  task automatic t_disable();
    send(OFF1);
    chk("R11 pre halt", halt, 1);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R11 halt off", halt, 0); chk("R11 flag off", flag, 0);
    send(OFF1);
    chk("R11 written", w1, 1); chk("R11 data", d1, OFF1); chk("R11 no halt", halt, 0);
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    en = 1'b1; irq_en = 1'b1;
    t_plain();
    t_single();
    t_noirq();
    t_pair();
    t_abandon();
    t_any();
    t_special();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule